// File: doc/BRIEF.md
# Streaming Fixed-Point Adder

This block adds two fixed-point operands and delivers the sum in a third fixed-point format. Each of the three terminals has its own signedness, its own total word length and its own count of integer bits; the remaining bits are fraction bits. The block lines up the binary points of the two operands and forms the exact sum. It reduces the sum to the result's fraction precision under a selectable rounding rule, then fits it into the result range by wrapping or by clamping.

Every result carries an operation-overflow flag. It can also carry an overflow status that merges the status bits arriving with the operands. The block takes one operand pair per clock. When built with its output register, it sits in a pipeline behind a valid/ready handshake and adds one cycle of latency. When built without it, the block is a pure combinational path.

Top module: `fixpt_add_stream`

## Requirements
- R1: Operands are read as two's complement when their signedness parameter is set and as plain binary otherwise, with fraction bits equal to word length minus integer bits (0 <= integer bits <= word length <= 64); the sum is formed exactly after aligning binary points.
- R2: Rounding mode 0 (truncate) drops the surplus fraction bits, which rounds toward minus infinity.
- R3: Rounding mode 1 (half-up) rounds to the nearest result step, and a tie goes toward plus infinity.
- R4: Rounding mode 2 (half-even) rounds to the nearest result step, and a tie goes to the step whose least significant bit is 0.
- R5: Rounding happens before the range check, so a round-up carry past the largest result value counts as overflow.
- R6: `opOvf` is high exactly when the rounded sum lies outside the range of the result format.
- R7: In overflow mode 0 (wrap), the result is the low result-word-length bits of the rounded sum.
- R8: In overflow mode 1 (saturate), an overflowing result becomes the largest or the smallest representable value; for an unsigned result, every negative sum gives 0.
- R9: With the status option on, `ovfStat` is the OR of both operand status bits and `opOvf`; with it off, `ovfStat` stays 0.
- R10: With the output register, a pair accepted at a clock edge appears on the outputs in the following cycle, and back-to-back pairs give one result per cycle.
- R11: `outValid` is never high while `outReady` is low, and a pending result together with its flags is held until it is taken.
- R12: With the output register, a pair presented in the cycle after a cycle in which `inReady` was low is discarded, even with `inValid` high.
- R13: Without the output register, the outputs follow the inputs in the same cycle, `inReady` is constantly high, and `outValid` equals `inValid` AND `outReady`.
- R14: Reset clears `outValid`, `opOvf` and `ovfStat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair present |
| inReady | output | 1 | Block can take a pair |
| opA | input | A_WL | First operand |
| opB | input | B_WL | Second operand |
| opAStat | input | 1 | Overflow status carried by the first operand |
| opBStat | input | 1 | Overflow status carried by the second operand |
| outReady | input | 1 | Downstream can take a result |
| outValid | output | 1 | Result present and being taken |
| sumOut | output | Y_WL | Rounded, range-fitted sum |
| opOvf | output | 1 | Overflow in this addition |
| ovfStat | output | 1 | Propagated overflow status |

## Verification
The assertions assume that once reset is released, `inValid`, `outReady` and the status inputs are known 0/1 values at every clock edge. They also assume that the parameters keep integer bits between zero and the word length. The stimulus changes every input shortly after a rising edge and holds it for the whole cycle. It only instantiates formats within those limits, so rounding, range checks and the handshake always see settled operands. `outReady` is toggled freely, including in the cycle right after `inReady` drops, because the discard rule must hold for any pattern.

// File: rtl/fxadd_pkg.sv
`timescale 1ns/1ps
package fxadd_pkg;
  localparam int RND_TRUNC     = 0;
  localparam int RND_HALF_UP   = 1;
  localparam int RND_HALF_EVEN = 2;
  localparam int OVF_WRAP      = 0;
  localparam int OVF_SAT       = 1;

  // strobes from the handshake control to the datapath
  typedef struct packed {
    logic load;   // capture the current sum into the output stage
  } fxadd_strobe_t;
endpackage

// File: rtl/fxadd_ctrl.sv
`timescale 1ns/1ps
module fxadd_ctrl
  import fxadd_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          outReady,
  output logic          inReady,
  output logic          outValid,
  output fxadd_strobe_t strb
);
  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      logic lastRdy;   // inReady as it was in the previous cycle
      logic accept;

      assign inReady  = !validQ || outReady;
      assign accept   = inValid && inReady && lastRdy;
      assign outValid = validQ && outReady;
      assign strb.load = accept;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validQ  <= 1'b0;
          lastRdy <= 1'b1;
        end else begin
          lastRdy <= inReady;
          if (accept)        validQ <= 1'b1;
          else if (outReady) validQ <= 1'b0;
        end
      end

      // R12: a cycle with inReady low blocks loading in the next one
      p_discard_r12: assert property (@(posedge clk) disable iff (!rstN)
        !inReady |=> !strb.load);
      // R11: a result not taken stays pending
      p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
        (validQ && !outReady) |=> validQ);
    end else begin : g_comb
      assign inReady   = 1'b1;
      assign outValid  = inValid && outReady;
      assign strb.load = inValid;
    end
  endgenerate
endmodule

// File: rtl/fxadd_datapath.sv
`timescale 1ns/1ps
module fxadd_datapath
  import fxadd_pkg::*;
#(
  parameter bit A_SIGNED  = 1'b1,
  parameter int A_WL      = 16,
  parameter int A_IWL     = 4,
  parameter bit B_SIGNED  = 1'b1,
  parameter int B_WL      = 12,
  parameter int B_IWL     = 6,
  parameter bit Y_SIGNED  = 1'b1,
  parameter int Y_WL      = 12,
  parameter int Y_IWL     = 6,
  parameter int RND_MODE  = RND_TRUNC,
  parameter int OVF_MODE  = OVF_WRAP,
  parameter bit STATUS_EN = 1'b0,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  fxadd_strobe_t   strb,
  input  logic [A_WL-1:0] opA,
  input  logic [B_WL-1:0] opB,
  input  logic            opAStat,
  input  logic            opBStat,
  output logic [Y_WL-1:0] sumOut,
  output logic            opOvf,
  output logic            ovfStat
);
  localparam int A_FR  = A_WL - A_IWL;
  localparam int B_FR  = B_WL - B_IWL;
  localparam int Y_FR  = Y_WL - Y_IWL;
  localparam int FW    = (A_FR > B_FR) ? ((A_FR > Y_FR) ? A_FR : Y_FR)
                                       : ((B_FR > Y_FR) ? B_FR : Y_FR);
  localparam int MAXI  = (A_IWL > B_IWL) ? ((A_IWL > Y_IWL) ? A_IWL : Y_IWL)
                                         : ((B_IWL > Y_IWL) ? B_IWL : Y_IWL);
  localparam int EW    = FW + MAXI + 3;   // sum, round carry and sign fit
  localparam int SH_A  = FW - A_FR;
  localparam int SH_B  = FW - B_FR;
  localparam int DROP  = FW - Y_FR;
  localparam int HSH   = (DROP > 0) ? DROP - 1 : 0;

  typedef logic signed [EW-1:0] wide_t;
  localparam wide_t ONE_W  = wide_t'(1);
  localparam wide_t HALF_W = (DROP > 0) ? (ONE_W <<< HSH) : wide_t'(0);
  localparam wide_t Y_MAX  = Y_SIGNED ? ((ONE_W <<< (Y_WL - 1)) - ONE_W)
                                      : ((ONE_W <<< Y_WL) - ONE_W);
  localparam wide_t Y_MIN  = Y_SIGNED ? -(ONE_W <<< (Y_WL - 1)) : wide_t'(0);

  logic  extA, extB, bump, ovfC, statC;
  wide_t aAl, bAl, sumW, flr, rem, rnd;
  logic [Y_WL-1:0] yC;

  always_comb begin
    extA = A_SIGNED && opA[A_WL-1];
    extB = B_SIGNED && opB[B_WL-1];
    aAl  = $signed({{(EW-A_WL){extA}}, opA}) <<< SH_A;
    bAl  = $signed({{(EW-B_WL){extB}}, opB}) <<< SH_B;
    sumW = aAl + bAl;
    flr  = sumW >>> DROP;                 // floor to the result step
    rem  = sumW - (flr <<< DROP);         // discarded part, 0 .. 2^DROP-1
    case (RND_MODE)
      RND_HALF_UP:   bump = (DROP > 0) && (rem >= HALF_W);
      RND_HALF_EVEN: bump = (DROP > 0) && ((rem > HALF_W) || ((rem == HALF_W) && flr[0]));
      default:       bump = 1'b0;
    endcase
    rnd  = flr + $signed({{(EW-1){1'b0}}, bump});
    ovfC = (rnd > Y_MAX) || (rnd < Y_MIN);
    if ((OVF_MODE == OVF_SAT) && ovfC)
      yC = (rnd > Y_MAX) ? Y_MAX[Y_WL-1:0] : Y_MIN[Y_WL-1:0];
    else
      yC = rnd[Y_WL-1:0];
    statC = STATUS_EN && (opAStat || opBStat || ovfC);
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [Y_WL-1:0] yQ;
      logic            ovfQ, statQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          yQ    <= '0;
          ovfQ  <= 1'b0;
          statQ <= 1'b0;
        end else if (strb.load) begin
          yQ    <= yC;
          ovfQ  <= ovfC;
          statQ <= statC;
        end
      end
      assign sumOut  = yQ;
      assign opOvf   = ovfQ;
      assign ovfStat = statQ;

      // R6: the flag of a loaded sum reaches the output one cycle later
      p_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
        strb.load |=> (opOvf == $past(ovfC)));
      // R9: an incoming status bit shows up when the option is on
      p_stat_r9: assert property (@(posedge clk) disable iff (!rstN)
        (strb.load && (opAStat || opBStat)) |=> (ovfStat == STATUS_EN));
      // R11: without a load the output stage keeps its contents
      p_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
        !strb.load |=> ($stable(sumOut) && $stable(opOvf) && $stable(ovfStat)));
    end else begin : g_comb
      assign sumOut  = yC;
      assign opOvf   = ovfC;
      assign ovfStat = statC;
    end
  endgenerate
endmodule

// File: rtl/fixpt_add_stream.sv
`timescale 1ns/1ps
module fixpt_add_stream
  import fxadd_pkg::*;
#(
  parameter bit A_SIGNED  = 1'b1,
  parameter int A_WL      = 16,
  parameter int A_IWL     = 4,
  parameter bit B_SIGNED  = 1'b1,
  parameter int B_WL      = 12,
  parameter int B_IWL     = 6,
  parameter bit Y_SIGNED  = 1'b1,
  parameter int Y_WL      = 12,
  parameter int Y_IWL     = 6,
  parameter int RND_MODE  = RND_TRUNC,
  parameter int OVF_MODE  = OVF_WRAP,
  parameter bit STATUS_EN = 1'b0,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  output logic            inReady,
  input  logic [A_WL-1:0] opA,
  input  logic [B_WL-1:0] opB,
  input  logic            opAStat,
  input  logic            opBStat,
  input  logic            outReady,
  output logic            outValid,
  output logic [Y_WL-1:0] sumOut,
  output logic            opOvf,
  output logic            ovfStat
);
  fxadd_strobe_t strb;

  fxadd_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .strb(strb)
  );

  fxadd_datapath #(
    .A_SIGNED(A_SIGNED), .A_WL(A_WL), .A_IWL(A_IWL),
    .B_SIGNED(B_SIGNED), .B_WL(B_WL), .B_IWL(B_IWL),
    .Y_SIGNED(Y_SIGNED), .Y_WL(Y_WL), .Y_IWL(Y_IWL),
    .RND_MODE(RND_MODE), .OVF_MODE(OVF_MODE),
    .STATUS_EN(STATUS_EN), .REG_OUT(REG_OUT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .opA(opA), .opB(opB), .opAStat(opAStat), .opBStat(opBStat),
    .sumOut(sumOut), .opOvf(opOvf), .ovfStat(ovfStat)
  );
endmodule

// File: tb/sim_fixpt_add_stream.sv
`timescale 1ns/1ps
module sim_fixpt_add_stream;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int nCmp = 0;
  int nBad = 0;
  int xferCnt = 0;
  bit done = 1'b0;

  // ---------- u0: registered, half-even, saturate, status on ----------
  logic       inValid0 = 0, outReady0 = 1, sa0 = 0, sb0 = 0;
  logic [7:0] a0 = 0;
  logic [5:0] b0 = 0;
  logic       inReady0, outValid0, ovf0, stat0;
  logic [5:0] y0;

  fixpt_add_stream #(
    .A_SIGNED(1), .A_WL(8), .A_IWL(4), .B_SIGNED(0), .B_WL(6), .B_IWL(4),
    .Y_SIGNED(1), .Y_WL(6), .Y_IWL(4), .RND_MODE(2), .OVF_MODE(1),
    .STATUS_EN(1), .REG_OUT(1)
  ) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid0), .inReady(inReady0),
    .opA(a0), .opB(b0), .opAStat(sa0), .opBStat(sb0), .outReady(outReady0),
    .outValid(outValid0), .sumOut(y0), .opOvf(ovf0), .ovfStat(stat0)
  );

  // ---------- u1: combinational, half-up, wrap, status off ----------
  logic       inValid1 = 0, outReady1 = 0, sa1 = 0, sb1 = 0;
  logic [7:0] a1 = 0, b1 = 0;
  logic       inReady1, outValid1, ovf1, stat1;
  logic [5:0] y1;

  fixpt_add_stream #(
    .A_SIGNED(1), .A_WL(8), .A_IWL(4), .B_SIGNED(1), .B_WL(8), .B_IWL(4),
    .Y_SIGNED(1), .Y_WL(6), .Y_IWL(3), .RND_MODE(1), .OVF_MODE(0),
    .STATUS_EN(0), .REG_OUT(0)
  ) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid1), .inReady(inReady1),
    .opA(a1), .opB(b1), .opAStat(sa1), .opBStat(sb1), .outReady(outReady1),
    .outValid(outValid1), .sumOut(y1), .opOvf(ovf1), .ovfStat(stat1)
  );

  // ---------- u2: combinational, truncate, saturate, unsigned result ----------
  logic       sa2 = 0, sb2 = 0;
  logic [7:0] a2 = 0, b2 = 0;
  logic       inReady2, outValid2, ovf2, stat2;
  logic [7:0] y2;

  fixpt_add_stream #(
    .A_SIGNED(1), .A_WL(8), .A_IWL(6), .B_SIGNED(1), .B_WL(8), .B_IWL(6),
    .Y_SIGNED(0), .Y_WL(8), .Y_IWL(8), .RND_MODE(0), .OVF_MODE(1),
    .STATUS_EN(1), .REG_OUT(0)
  ) u2 (
    .clk(clk), .rstN(rstN), .inValid(1'b1), .inReady(inReady2),
    .opA(a2), .opB(b2), .opAStat(sa2), .opBStat(sb2), .outReady(1'b1),
    .outValid(outValid2), .sumOut(y2), .opOvf(ovf2), .ovfStat(stat2)
  );

  // Reference: returns {status, overflow, result bits}
  function automatic logic [65:0] model(longint a, longint b,
      int aw, int ai, bit as_, int bw, int bi, bit bs_,
      int yw, int yi, bit ys, int rm, bit sat, bit sten, bit sa, bit sb);
    int af = aw - ai, bf = bw - bi, yf = yw - yi;
    int fw = af;
    int d;
    longint s, q, rem, half, mx, mn, y;
    bit o;
    if (bf > fw) fw = bf;
    if (yf > fw) fw = yf;
    if (as_ && a[aw-1]) a = a - (longint'(1) <<< aw);
    if (bs_ && b[bw-1]) b = b - (longint'(1) <<< bw);
    s = (a <<< (fw - af)) + (b <<< (fw - bf));
    d = fw - yf;
    q = s >>> d;
    rem = s - (q <<< d);
    if (d > 0) begin
      half = longint'(1) <<< (d - 1);
      if (rm == 1 && rem >= half) q = q + 1;
      if (rm == 2 && (rem > half || (rem == half && q[0]))) q = q + 1;
    end
    mx = ys ? (longint'(1) <<< (yw - 1)) - 1 : (longint'(1) <<< yw) - 1;
    mn = ys ? -(longint'(1) <<< (yw - 1)) : 0;
    o = (q > mx) || (q < mn);
    y = (sat && o) ? ((q > mx) ? mx : mn) : q;
    y = y & ((longint'(1) <<< yw) - 1);
    return {sten && (sa || sb || o), o, 64'(y)};
  endfunction

  task automatic chk(string tag, longint got, longint exp);
    nCmp++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  // ---------- scoreboard for u0 ----------
  logic [7:0] expQ[$];
  bit readyPrev = 1'b1;

  always @(negedge clk) begin
    if (!rstN) begin
      readyPrev = 1'b1;
    end else begin
      if (!outReady0) chk("R11 outValid while outReady low", outValid0, 0);
      if (outValid0) begin
        xferCnt++;
        if (expQ.size() == 0) chk("R12 unexpected result", 1, 0);
        else chk("R1 R4 R5 R6 R8 R9 result", {stat0, ovf0, y0}, expQ.pop_front());
      end
      if (inValid0 && inReady0 && readyPrev) begin
        logic [65:0] m;
        m = model(a0, b0, 8, 4, 1, 6, 4, 0, 6, 4, 1, 2, 1, 1, sa0, sb0);
        expQ.push_back({m[65], m[64], m[5:0]});
      end
      readyPrev = inReady0;
    end
  end

  task automatic send(logic [7:0] a, logic [5:0] b, bit sa, bit sb);
    @(posedge clk); #2;
    inValid0 = 1; a0 = a; b0 = b; sa0 = sa; sb0 = sb;
  endtask

  task automatic idle();
    @(posedge clk); #2;
    inValid0 = 0;
  endtask

  task automatic comb1(logic [7:0] a, logic [7:0] b, string tag);
    logic [65:0] m;
    a1 = a; b1 = b; sa1 = 1; sb1 = 1;
    #1;
    m = model(a, b, 8, 4, 1, 8, 4, 1, 6, 3, 1, 1, 0, 0, 1, 1);
    chk(tag, {stat1, ovf1, y1}, {m[65], m[64], m[5:0]});
  endtask

  task automatic comb2(logic [7:0] a, logic [7:0] b, bit sa, string tag);
    logic [65:0] m;
    a2 = a; b2 = b; sa2 = sa; sb2 = 0;
    #1;
    m = model(a, b, 8, 6, 1, 8, 6, 1, 8, 8, 0, 0, 1, 1, sa, 0);
    chk(tag, {stat2, ovf2, y2}, {m[65], m[64], m[7:0]});
  endtask

  logic [7:0] ta[9];
  logic [5:0] tb[9];

  initial begin
    int x0;
    // ties, carries and clamps in the u0 format (1/16 and 1/4 steps)
    ta[0] = 8'h02; tb[0] = 6'h00;  // tie, even -> 0
    ta[1] = 8'h06; tb[1] = 6'h00;  // tie, odd -> up
    ta[2] = 8'h7E; tb[2] = 6'h00;  // round carry overflows -> clamp
    ta[3] = 8'h70; tb[3] = 6'h3F;  // large positive -> clamp max
    ta[4] = 8'h80; tb[4] = 6'h00;  // most negative, exact
    ta[5] = 8'hF0; tb[5] = 6'h01;  // -1.0 + 0.25
    ta[6] = 8'h10; tb[6] = 6'h04;  // status from operand
    ta[7] = 8'h81; tb[7] = 6'h00;  // below half, rounds down
    ta[8] = 8'hFA; tb[8] = 6'h00;  // negative tie, even

    // reset state (R14)
    repeat (3) @(negedge clk);
    chk("R14 outValid in reset", outValid0, 0);
    chk("R14 opOvf in reset", ovf0, 0);
    chk("R14 ovfStat in reset", stat0, 0);
    @(posedge clk); #2; rstN = 1;
    @(negedge clk);
    chk("R14 outValid after reset", outValid0, 0);
    chk("R14 flags after reset", {ovf0, stat0}, 0);

    // latency (R10)
    send(8'h7E, 6'h00, 0, 0);
    @(negedge clk);
    chk("R10 no output in accept cycle", outValid0, 0);
    idle();
    @(negedge clk);
    chk("R10 output one cycle later", outValid0, 1);
    idle(); idle();

    // throughput (R10)
    x0 = xferCnt;
    for (int i = 0; i < 9; i++) send(ta[i], tb[i], i == 6, 0);
    idle(); idle(); idle();
    chk("R10 one result per cycle", xferCnt - x0, 9);

    // backpressure pattern (R11)
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #2;
      outReady0 = (i % 3) != 1;
      inValid0 = 1; a0 = ta[i % 9]; b0 = tb[(i + 2) % 9];
      sa0 = (i % 5) == 0; sb0 = (i % 7) == 3;
    end
    @(posedge clk); #2; inValid0 = 0; outReady0 = 1;
    idle(); idle(); idle();

    // discard after a not-ready cycle (R12)
    x0 = xferCnt;
    @(posedge clk); #2; outReady0 = 0; inValid0 = 1; a0 = 8'h06; b0 = 6'h01;
    @(posedge clk); #2; inValid0 = 0;
    @(negedge clk);
    chk("R12 inReady low while full", inReady0, 0);
    @(posedge clk); #2; outReady0 = 1; inValid0 = 1; a0 = 8'h30; b0 = 6'h05;
    idle(); idle(); idle(); idle();
    chk("R12 pair after not-ready cycle dropped", xferCnt - x0, 1);
    chk("R12 scoreboard drained", expQ.size(), 0);

    // combinational instance u1 (R3 R7 R9 R13)
    inValid1 = 1; outReady1 = 1;
    comb1(8'h01, 8'h00, "R3 tie rounds up");
    comb1(8'hFF, 8'h00, "R3 negative tie rounds toward plus");
    comb1(8'h30, 8'h20, "R7 wrap on overflow");
    comb1(8'hC0, 8'hB0, "R7 wrap negative overflow");
    comb1(8'h15, 8'h0A, "R1 aligned sum");
    chk("R9 status off stays low", stat1, 0);
    chk("R13 inReady constant", inReady1, 1);
    chk("R13 valid passes", outValid1, 1);
    outReady1 = 0; #1;
    chk("R13 valid gated by outReady", outValid1, 0);
    inValid1 = 0; outReady1 = 1; #1;
    chk("R13 valid follows input", outValid1, 0);

    // combinational instance u2 (R2 R8 R9)
    comb2(8'h07, 8'h00, 0, "R2 truncate 1.75");
    comb2(8'hFF, 8'h00, 0, "R8 negative clamps to zero");
    comb2(8'h80, 8'h80, 0, "R8 most negative clamps to zero");
    comb2(8'h7F, 8'h7F, 1, "R9 status from operand");
    comb2(8'h0B, 8'h06, 0, "R2 truncate sum");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule